// File: doc/BRIEF.md
# Multi-write micro-op sequencer

This block sits in the issue stage of a small in-order core whose register file has two read ports and a single write port. Each decoded instruction comes in on a valid/ready handshake. The sequencer expands it into a run of micro-operations, issued one per cycle, and each micro-operation writes at most one register. It covers the following instruction classes:

- plain operations
- single loads, including post-increment
- single stores, including the register-offset form
- load-multiple and store-multiple of 1 to 8 or 12 words, with an optional trailing base write
- double-word moves
- divides, which return a quotient and a remainder
- multiply-accumulate

Each cycle the output side presents one micro-operation: its kind, its write enable and destination, two source register selects, and a flag that marks the last step. Back-pressure comes from the `uop_stall` input. While stall is high, the presented micro-op stays frozen and no new instruction is taken. An instruction is accepted only when the sequencer is idle, or in the cycle its final micro-op issues. The first micro-op of an accepted instruction is presented in the next cycle. A sequence that is not stalled therefore runs back to back with no bubbles.

Top module: `mwrite_uop_seq`

## Requirements
- R1: After reset `uop_valid` is 0 and, with `uop_stall` low, `in_ready` is 1.
- R2: `in_ready` equals `!uop_stall && (no micro-op presented || uop_last)`. The first micro-op of an accepted instruction is presented in the cycle after acceptance. One micro-op retires per cycle in which `uop_valid` is 1 and `uop_stall` is 0.
- R3: While `uop_stall` is 1, every micro-op output holds its value and no instruction is accepted.
- R4: Class 0 (plain) gives one micro-op of kind 0. It writes rt, reads ra and rb, and has `uop_last` set in that same cycle.
- R5: Class 1 (load) gives kind 1, which writes rt and reads ra. With base update set, a second micro-op of kind 3 writes ra and reads ra.
- R6: Class 2 (store) writes no register. With register-offset clear, it gives one kind-2 micro-op reading ra and rt. With register-offset set, it gives kind 10 (reads ra, rb), then kind 11 (reads ra, rt).
- R7: Class 3 (load-multiple) of count N (1..8 or 12) gives N kind-1 micro-ops. Word i writes (rt+i) mod 2^REG_W and reads ra.
- R8: Class 4 (store-multiple) of count N gives N kind-2 micro-ops that write nothing. Word i reads ra and (rt+i) mod 2^REG_W.
- R9: For classes 3 and 4 with base update set, one extra trailing micro-op of kind 3 writes ra and reads ra.
- R10: Class 5 (double move) gives kind 4, which writes rt with bit 0 cleared and reads ra with bit 0 cleared. It then gives kind 5, which writes rt with bit 0 set and reads ra with bit 0 set.
- R11: Class 6 (divide) gives kind 6, which writes rt, then kind 7, which writes rs. Both read ra and rb.
- R12: Class 7 (multiply-accumulate) gives kind 8, which reads ra and rb and writes nothing. It then gives kind 9, which writes rt and reads rt.
- R13: Base update has no effect on classes 0, 2, 5, 6 and 7. Register-offset has no effect on any class but 2.
- R14: `uop_last` is 1 only on the final micro-op of a sequence. A destination with write disabled, and any unused source select, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction offered |
| in_ready | output | 1 | Instruction taken this cycle when in_valid is 1 |
| in_class | input | 3 | Instruction class code (0..7, see R4-R12) |
| in_base_upd | input | 1 | Base register update requested |
| in_reg_off | input | 1 | Store offset comes from a register |
| in_count | input | CNT_W | Word count for multiple transfers |
| in_rt | input | REG_W | Target / first data register |
| in_rs | input | REG_W | Second result register |
| in_ra | input | REG_W | Base or first source register |
| in_rb | input | REG_W | Second source register |
| uop_valid | output | 1 | A micro-op is presented |
| uop_stall | input | 1 | Hold the presented micro-op |
| uop_kind | output | 4 | Micro-op kind code |
| uop_wr_en | output | 1 | Micro-op writes a register |
| uop_wr_reg | output | REG_W | Destination register |
| uop_src_a | output | REG_W | First read select |
| uop_src_b | output | REG_W | Second read select |
| uop_last | output | 1 | Final micro-op of the sequence |

## Verification
A corrupted step counter or a wrong latched length shows up at the ports in the next presented micro-op. The symptom is a wrong destination, a missing or extra trailing base write, or `uop_last` appearing early or late. `in_ready` then disagrees with the expected handshake in that same cycle. A latched class or register that goes bad mid-sequence appears as a wrong kind or select on the very next micro-op. A stall that fails to freeze state is visible one cycle later as a changed micro-op while stall is still high.

// File: rtl/mwseq_pkg.sv
package mwseq_pkg;

  typedef enum logic [2:0] {
    CL_PLAIN = 3'd0,
    CL_LOAD  = 3'd1,
    CL_STORE = 3'd2,
    CL_LDM   = 3'd3,
    CL_STM   = 3'd4,
    CL_MOVD  = 3'd5,
    CL_DIV   = 3'd6,
    CL_MAC   = 3'd7
  } ins_class_e;

  typedef enum logic [3:0] {
    UK_ALU    = 4'd0,
    UK_LD     = 4'd1,
    UK_ST     = 4'd2,
    UK_BASE   = 4'd3,
    UK_MV_EV  = 4'd4,
    UK_MV_OD  = 4'd5,
    UK_QUO    = 4'd6,
    UK_REM    = 4'd7,
    UK_MUL    = 4'd8,
    UK_ACC    = 4'd9,
    UK_STADDR = 4'd10,
    UK_STDATA = 4'd11
  } uop_kind_e;

  // Classes whose base-update flag adds a trailing write.
  function automatic logic base_honoured(ins_class_e c);
    return (c == CL_LOAD) || (c == CL_LDM) || (c == CL_STM);
  endfunction

endpackage

// File: rtl/mwseq_len_calc.sv
module mwseq_len_calc
  import mwseq_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int LEN_W = CNT_W + 1
) (
  input  ins_class_e         cls,
  input  logic               base_upd,
  input  logic               reg_off,
  input  logic [CNT_W-1:0]   count,
  output logic [LEN_W-1:0]   len
);

  logic [LEN_W-1:0] words;
  logic [LEN_W-1:0] bu_add;
  logic [LEN_W-1:0] ro_add;

  assign words  = (count == '0) ? LEN_W'(1) : LEN_W'(count);
  assign bu_add = (base_upd && base_honoured(cls)) ? LEN_W'(1) : '0;
  assign ro_add = reg_off ? LEN_W'(1) : '0;

  always_comb begin
    case (cls)
      CL_PLAIN:       len = LEN_W'(1);
      CL_LOAD:        len = LEN_W'(1) + bu_add;
      CL_STORE:       len = LEN_W'(1) + ro_add;
      CL_LDM, CL_STM: len = words + bu_add;
      default:        len = LEN_W'(2);
    endcase
  end

endmodule

// File: rtl/mwseq_uop_gen.sv
module mwseq_uop_gen
  import mwseq_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int LEN_W = 5
) (
  input  ins_class_e        cls,
  input  logic              base_upd,
  input  logic              reg_off,
  input  logic [REG_W-1:0]  rt,
  input  logic [REG_W-1:0]  rs,
  input  logic [REG_W-1:0]  ra,
  input  logic [REG_W-1:0]  rb,
  input  logic [LEN_W-1:0]  idx,
  input  logic [LEN_W-1:0]  len,
  output uop_kind_e         kind,
  output logic              wr_en,
  output logic [REG_W-1:0]  wr_reg,
  output logic [REG_W-1:0]  src_a,
  output logic [REG_W-1:0]  src_b,
  output logic              last
);

  logic             first;
  logic             tail_base;
  logic [REG_W-1:0] walk;
  logic [REG_W-1:0] rt_even;
  logic [REG_W-1:0] ra_even;

  assign last      = (idx == len - LEN_W'(1));
  assign first     = (idx == '0);
  assign tail_base = base_upd && last;
  assign walk      = rt + REG_W'(idx);
  assign rt_even   = {rt[REG_W-1:1], 1'b0};
  assign ra_even   = {ra[REG_W-1:1], 1'b0};

  always_comb begin
    kind   = UK_ALU;
    wr_en  = 1'b0;
    wr_reg = '0;
    src_a  = '0;
    src_b  = '0;
    case (cls)
      CL_PLAIN: begin
        kind = UK_ALU; wr_en = 1'b1; wr_reg = rt; src_a = ra; src_b = rb;
      end
      CL_LOAD: begin
        kind   = first ? UK_LD : UK_BASE;
        wr_en  = 1'b1;
        wr_reg = first ? rt : ra;
        src_a  = ra;
      end
      CL_STORE: begin
        src_a = ra;
        if (!reg_off) begin
          kind = UK_ST; src_b = rt;
        end else if (first) begin
          kind = UK_STADDR; src_b = rb;
        end else begin
          kind = UK_STDATA; src_b = rt;
        end
      end
      CL_LDM: begin
        src_a = ra;
        wr_en = 1'b1;
        if (tail_base) begin
          kind = UK_BASE; wr_reg = ra;
        end else begin
          kind = UK_LD; wr_reg = walk;
        end
      end
      CL_STM: begin
        src_a = ra;
        if (tail_base) begin
          kind = UK_BASE; wr_en = 1'b1; wr_reg = ra;
        end else begin
          kind = UK_ST; src_b = walk;
        end
      end
      CL_MOVD: begin
        wr_en = 1'b1;
        if (first) begin
          kind = UK_MV_EV; wr_reg = rt_even; src_a = ra_even;
        end else begin
          kind = UK_MV_OD; wr_reg = rt_even | REG_W'(1); src_a = ra_even | REG_W'(1);
        end
      end
      CL_DIV: begin
        kind   = first ? UK_QUO : UK_REM;
        wr_en  = 1'b1;
        wr_reg = first ? rt : rs;
        src_a  = ra;
        src_b  = rb;
      end
      CL_MAC: begin
        if (first) begin
          kind = UK_MUL; src_a = ra; src_b = rb;
        end else begin
          kind = UK_ACC; wr_en = 1'b1; wr_reg = rt; src_a = rt;
        end
      end
      default: kind = UK_ALU;
    endcase
  end

endmodule

// File: rtl/mwrite_uop_seq.sv
module mwrite_uop_seq
  import mwseq_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_class,
  input  logic              in_base_upd,
  input  logic              in_reg_off,
  input  logic [CNT_W-1:0]  in_count,
  input  logic [REG_W-1:0]  in_rt,
  input  logic [REG_W-1:0]  in_rs,
  input  logic [REG_W-1:0]  in_ra,
  input  logic [REG_W-1:0]  in_rb,
  output logic              uop_valid,
  input  logic              uop_stall,
  output logic [3:0]        uop_kind,
  output logic              uop_wr_en,
  output logic [REG_W-1:0]  uop_wr_reg,
  output logic [REG_W-1:0]  uop_src_a,
  output logic [REG_W-1:0]  uop_src_b,
  output logic              uop_last
);

  localparam int LEN_W = CNT_W + 1;
  localparam int NREG  = 4;   // rt, rs, ra, rb

  ins_class_e       in_cls;
  ins_class_e       held_cls;
  logic             held_bu;
  logic             held_ro;
  logic             active;
  logic [LEN_W-1:0] in_len;
  logic [LEN_W-1:0] held_len;
  logic [LEN_W-1:0] step;
  logic             accept;
  logic             advance;
  logic             g_last;
  uop_kind_e        g_kind;

  logic [REG_W-1:0] in_regs   [NREG];
  logic [REG_W-1:0] held_regs [NREG];

  assign in_cls     = ins_class_e'(in_class);
  assign in_regs[0] = in_rt;
  assign in_regs[1] = in_rs;
  assign in_regs[2] = in_ra;
  assign in_regs[3] = in_rb;

  mwseq_len_calc #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_len (
    .cls      (in_cls),
    .base_upd (in_base_upd),
    .reg_off  (in_reg_off),
    .count    (in_count),
    .len      (in_len)
  );

  // Take a new instruction when idle or as the final step leaves.
  assign in_ready = !uop_stall && (!active || g_last);
  assign accept   = in_valid && in_ready;
  assign advance  = active && !uop_stall;

  for (genvar g = 0; g < NREG; g++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rst_n)      held_regs[g] <= '0;
      else if (accept) held_regs[g] <= in_regs[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      step     <= '0;
      held_len <= '0;
      held_cls <= CL_PLAIN;
      held_bu  <= 1'b0;
      held_ro  <= 1'b0;
    end else if (accept) begin
      active   <= 1'b1;
      step     <= '0;
      held_len <= in_len;
      held_cls <= in_cls;
      held_bu  <= in_base_upd && base_honoured(in_cls);
      held_ro  <= in_reg_off && (in_cls == CL_STORE);
    end else if (advance) begin
      if (g_last) active <= 1'b0;
      else        step   <= step + LEN_W'(1);
    end
  end

  mwseq_uop_gen #(.REG_W(REG_W), .LEN_W(LEN_W)) u_gen (
    .cls      (held_cls),
    .base_upd (held_bu),
    .reg_off  (held_ro),
    .rt       (held_regs[0]),
    .rs       (held_regs[1]),
    .ra       (held_regs[2]),
    .rb       (held_regs[3]),
    .idx      (step),
    .len      (held_len),
    .kind     (g_kind),
    .wr_en    (uop_wr_en),
    .wr_reg   (uop_wr_reg),
    .src_a    (uop_src_a),
    .src_b    (uop_src_b),
    .last     (g_last)
  );

  assign uop_valid = active;
  assign uop_kind  = g_kind;
  assign uop_last  = g_last;

endmodule

// File: rtl/mwseq_chk.sv
module mwseq_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             uop_stall,
  input logic             uop_valid,
  input logic [3:0]       uop_kind,
  input logic             uop_wr_en,
  input logic [REG_W-1:0] uop_wr_reg,
  input logic [REG_W-1:0] uop_src_a,
  input logic [REG_W-1:0] uop_src_b,
  input logic             uop_last
);

  a_r2_ready_needs_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !uop_stall);

  a_r2_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!uop_valid && !uop_stall) |-> in_ready);

  a_r2_mid_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && !uop_last) |-> !in_ready);

  a_r2_accept_then_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> uop_valid);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_stall) |=> (uop_valid && $stable(uop_kind) && $stable(uop_wr_en)
      && $stable(uop_wr_reg) && $stable(uop_src_a) && $stable(uop_src_b) && $stable(uop_last)));

  a_r4_plain_single: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_kind == 4'd0) |-> uop_last);

  a_r10_even_first: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_kind == 4'd4) |-> (!uop_last && !uop_wr_reg[0]));

  a_r12_mul_then_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && !uop_stall && uop_kind == 4'd8) |=> (uop_valid && uop_kind == 4'd9));

  a_r14_quiet_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && !uop_wr_en) |-> (uop_wr_reg == '0));

endmodule

bind mwrite_uop_seq mwseq_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/tb_mwrite_uop_seq.sv
`timescale 1ns/1ps
module tb_mwrite_uop_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_class = '0;
  logic       in_base_upd = 1'b0;
  logic       in_reg_off = 1'b0;
  logic [3:0] in_count = 4'd1;
  logic [4:0] in_rt = '0, in_rs = '0, in_ra = '0, in_rb = '0;
  logic       uop_valid;
  logic       uop_stall = 1'b0;
  logic [3:0] uop_kind;
  logic       uop_wr_en;
  logic [4:0] uop_wr_reg, uop_src_a, uop_src_b;
  logic       uop_last;

  always #4 clk = ~clk;   // 125 MHz

  mwrite_uop_seq dut (.*);

  int checks = 0;
  int fails  = 0;
  bit accepted;
  logic [20:0] expq[$];
  string       tagq[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int exp_len(int c, bit bu, bit ro, int cnt);
    case (c)
      0: return 1;
      1: return 1 + int'(bu);
      2: return 1 + int'(ro);
      3, 4: return cnt + int'(bu);
      default: return 2;
    endcase
  endfunction

  // Packed as {kind, wr_en, wr_reg, src_a, src_b, last}.
  function automatic logic [20:0] model(int c, bit bu, bit ro, int rt, int rs,
                                        int ra, int rb, int i, int n);
    int k = 0, we = 0, wr = 0, sa = 0, sb = 0;
    bit last = (i == n - 1);
    case (c)
      0: begin k = 0; we = 1; wr = rt; sa = ra; sb = rb; end
      1: if (i == 0) begin k = 1; we = 1; wr = rt; sa = ra; end
         else begin k = 3; we = 1; wr = ra; sa = ra; end
      2: if (!ro) begin k = 2; sa = ra; sb = rt; end
         else if (i == 0) begin k = 10; sa = ra; sb = rb; end
         else begin k = 11; sa = ra; sb = rt; end
      3: if (bu && last) begin k = 3; we = 1; wr = ra; sa = ra; end
         else begin k = 1; we = 1; wr = (rt + i) % 32; sa = ra; end
      4: if (bu && last) begin k = 3; we = 1; wr = ra; sa = ra; end
         else begin k = 2; sa = ra; sb = (rt + i) % 32; end
      5: if (i == 0) begin k = 4; we = 1; wr = rt & 30; sa = ra & 30; end
         else begin k = 5; we = 1; wr = rt | 1; sa = ra | 1; end
      6: begin k = (i == 0) ? 6 : 7; we = 1; wr = (i == 0) ? rt : rs; sa = ra; sb = rb; end
      default: if (i == 0) begin k = 8; sa = ra; sb = rb; end
               else begin k = 9; we = 1; wr = rt; sa = rt; end
    endcase
    return {k[3:0], we[0], wr[4:0], sa[4:0], sb[4:0], last};
  endfunction

  function automatic string tag_of(int c, bit bu, bit ro, bit is_base);
    string t;
    case (c)
      0: t = "R4";
      1: t = "R5";
      2: t = "R6";
      3: t = is_base ? "R9" : "R7";
      4: t = is_base ? "R9" : "R8";
      5: t = "R10";
      6: t = "R11";
      default: t = "R12";
    endcase
    if ((bu && !(c == 1 || c == 3 || c == 4)) || (ro && c != 2)) t = {t, "/R13"};
    return {t, "/R14"};
  endfunction

  task automatic eval();
    bit ev = (expq.size() > 0);
    bit er;
    logic [20:0] got = {uop_kind, uop_wr_en, uop_wr_reg, uop_src_a, uop_src_b, uop_last};
    check(uop_valid == ev, "R2", "uop_valid", 32'(uop_valid), 32'(ev));
    if (ev && uop_valid) check(got == expq[0], tagq[0], "uop", 32'(got), 32'(expq[0]));
    er = !uop_stall && (!ev || expq[0][0]);
    check(in_ready == er, uop_stall ? "R3" : "R2", "in_ready", 32'(in_ready), 32'(er));
    if (ev && !uop_stall) begin
      void'(expq.pop_front());
      void'(tagq.pop_front());
    end
    if (in_valid && in_ready) begin
      int c = int'(in_class);
      int n = exp_len(c, in_base_upd, in_reg_off, int'(in_count));
      for (int i = 0; i < n; i++) begin
        logic [20:0] u = model(c, in_base_upd, in_reg_off, int'(in_rt), int'(in_rs),
                               int'(in_ra), int'(in_rb), i, n);
        expq.push_back(u);
        tagq.push_back(tag_of(c, in_base_upd, in_reg_off, u[20:17] == 4'd3));
      end
      accepted = 1'b1;
    end
  endtask

  task automatic tick(input int stall_pct);
    @(negedge clk);
    uop_stall = (int'($urandom % 100) < stall_pct);
    #2;
    eval();
    @(posedge clk);
    #1;
  endtask

  task automatic run_instr(input int c, input bit bu, input bit ro, input int cnt,
                           input int rt, input int rs, input int ra, input int rb,
                           input int stall_pct);
    in_class = 3'(c); in_base_upd = bu; in_reg_off = ro; in_count = 4'(cnt);
    in_rt = 5'(rt); in_rs = 5'(rs); in_ra = 5'(ra); in_rb = 5'(rb);
    in_valid = 1'b1;
    accepted = 1'b0;
    for (int g = 0; g < 2000 && !accepted; g++) tick(stall_pct);
    in_valid = 1'b0;
  endtask

  task automatic drain(input int n, input int stall_pct);
    in_valid = 1'b0;
    for (int g = 0; g < n; g++) tick(stall_pct);
  endtask

  initial begin
    #1600000;
    checks++;
    fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(uop_valid == 1'b0, "R1", "uop_valid after reset", 32'(uop_valid), 32'd0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'd1);
    @(posedge clk);
    #1;

    run_instr(0, 0, 0, 1, 3, 4, 5, 6, 0);     // R4 plain op
    run_instr(1, 0, 0, 1, 9, 0, 2, 0, 0);     // R5 load, no update
    run_instr(1, 1, 0, 1, 9, 0, 2, 0, 0);     // R5 post-increment load
    run_instr(2, 0, 0, 1, 8, 0, 4, 12, 0);    // R6 immediate-offset store
    run_instr(2, 0, 1, 1, 8, 0, 4, 12, 0);    // R6 register-offset store
    run_instr(3, 0, 0, 12, 25, 0, 1, 0, 0);   // R7 twelve words, wraps past 31
    run_instr(3, 1, 0, 8, 2, 0, 20, 0, 0);    // R9 load-multiple with base write
    run_instr(4, 0, 0, 1, 6, 0, 3, 0, 0);     // R8 one word, no update
    run_instr(4, 1, 0, 12, 28, 0, 10, 0, 0);  // R8 R9 store-multiple with base write
    run_instr(5, 0, 0, 1, 7, 0, 3, 0, 0);     // R10 odd operands still split even/odd
    run_instr(6, 1, 1, 1, 11, 12, 13, 14, 0); // R11 R13 divide ignores both flags
    run_instr(7, 1, 0, 1, 15, 0, 16, 17, 0);  // R12 R13 multiply-accumulate
    run_instr(0, 1, 1, 1, 1, 2, 3, 4, 0);     // R13 plain op ignores both flags
    drain(3, 0);

    // R3: stalled while idle with an offer pending, then stalled mid-sequence
    in_class = 3'd3; in_base_upd = 1'b1; in_reg_off = 1'b0; in_count = 4'd5;
    in_rt = 5'd30; in_rs = '0; in_ra = 5'd7; in_rb = '0;
    in_valid = 1'b1;
    accepted = 1'b0;
    for (int g = 0; g < 4; g++) tick(100);
    check(accepted == 1'b0, "R3", "accepted under stall", 32'(accepted), 32'd0);
    for (int g = 0; g < 50 && !accepted; g++) tick(0);
    in_valid = 1'b0;
    tick(0);
    for (int g = 0; g < 5; g++) tick(100);
    drain(10, 0);

    for (int it = 0; it < 2500; it++) begin
      int sel = int'($urandom % 9);
      run_instr(int'($urandom % 8), 1'($urandom), 1'($urandom), (sel < 8) ? sel + 1 : 12,
                int'($urandom % 32), int'($urandom % 32), int'($urandom % 32),
                int'($urandom % 32), 25);
      if ($urandom % 5 == 0) drain(1 + int'($urandom % 3), 25);
    end
    drain(20, 0);
    check(expq.size() == 0, "R2", "sequences drained", 32'(expq.size()), 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule